// File: doc/BRIEF.md
# Single-Wire Debug Abort and Acknowledge Timer

This block is the target-side timing logic for a bidirectional single-wire debug pin. It runs on the target's debug serial clock and models the pin as open-drain. The block outputs a drive enable and a drive value, and it receives the sampled pin level back. It measures host low pulses on the pin. A low level of at least 128 serial clock cycles is taken as a synchronisation request. That request aborts any command that is in flight. After the host lets go of the pin, the block answers with a timed reference pulse, which lets the host measure the target clock rate.

When the command engine reports that a command has finished, the block drives a self-timed acknowledge. The acknowledge is a fixed low pulse closed by one cycle of active-high drive, which speeds up the pin's rise. Shorter host pulses are not interpreted here. They reach the bit receiver through the synchronised level output.

While the target drives the pin, its own drive is hidden from pulse measurement. A host pulse that collides with the acknowledge is not arbitrated, and the acknowledge runs to its end. There is no data stream at this boundary: all pins are plain level or strobe controls, with no valid/ready handshake and no back-pressure.

Top module: `dbg1w_sync_ack`

## Requirements
- R1: A host low level of at least 128 clock cycles, measured on the synchronised input and ending with a rising edge, is taken as a synchronisation request. A low level of 127 cycles or fewer is not.
- R2: `rx_level` follows `pin_in` through two flops. A change on `pin_in` shows up after the second rising clock edge. Short host pulses produce neither a drive nor an abort.
- R3: A qualified request raises `cmd_abort` for exactly one cycle, on the 3rd clock edge after the host release, when `cmd_busy` or `cmd_done` is high in the qualifying cycle. Otherwise `cmd_abort` stays low.
- R4: The response begins on the 19th edge after the host release (a 16-cycle gap plus 3 cycles of input latency). It holds `pin_oe`=1 with `pin_out`=0 for 128 cycles, then `pin_oe`=1 with `pin_out`=1 for one cycle, then sets `pin_oe`=0.
- R5: Once the response is over, the block is idle. A `cmd_done` strobe given at once is acknowledged on the next edge.
- R6: A `cmd_done` strobe sampled while the block is idle starts the acknowledge on the next edge. The acknowledge is 16 cycles of `pin_oe`=1 with `pin_out`=0, then one cycle of `pin_oe`=1 with `pin_out`=1, then `pin_oe`=0.
- R7: The low-pulse counter saturates. A host low level of any length produces exactly one response.
- R8: A host low pulse that overlaps the target's own drive is not detected. The acknowledge keeps its length, and no response follows.
- R9: If `cmd_done` arrives in the same cycle that a request qualifies, the request wins. No acknowledge is driven, `cmd_abort` pulses, and the response follows with R4 timing.
- R10: After reset, `pin_oe`=0, `cmd_abort`=0 and `rx_level`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target debug serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Sampled level of the debug pin |
| cmd_busy | input | 1 | A command is being received or executed |
| cmd_done | input | 1 | One-cycle strobe: a command has completed |
| pin_oe | output | 1 | Target drives the pin when high |
| pin_out | output | 1 | Value driven on the pin while `pin_oe` is high |
| rx_level | output | 1 | Synchronised pin level for the bit receiver |
| cmd_abort | output | 1 | One-cycle strobe: the command in flight is aborted |

## Verification
Some properties are checked on every cycle by assertions:
- the abort strobe lasts one cycle and always follows a qualified request;
- every target drive begins low;
- the speedup cycle is always followed by release;
- a cycle with target drive never qualifies a request;
- a request that meets a completion strobe yields no acknowledge.

Other properties only the bench scenarios can show. These are the 128-cycle boundary, the exact edge counts from host release to abort and to response, and the pulse lengths. They also include saturation under a very long low level, the overlap of a host pulse with an acknowledge, and a prompt acknowledge right after a response.

// File: rtl/dbg1w_pkg.sv
package dbg1w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_RSP_WAIT,
    ST_RSP_LO,
    ST_RSP_HI
  } seq_state_t;
endpackage

// File: rtl/dbg1w_sync2.sv
module dbg1w_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dbg1w_low_meter.sv
module dbg1w_low_meter #(
  parameter int SYNC_MIN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_level,
  input  logic mask,
  output logic sync_hit
);
  localparam int CW = $clog2(SYNC_MIN + 1);

  logic          prev_q;
  logic          meas_q;
  logic [CW-1:0] cnt_q;
  logic          fall, rise;

  assign fall     = prev_q & ~rx_level;
  assign rise     = ~prev_q & rx_level;
  assign sync_hit = rise & meas_q & ~mask & (cnt_q == CW'(SYNC_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      meas_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= rx_level;
      if (mask) begin
        meas_q <= 1'b0;
        cnt_q  <= '0;
      end else if (fall) begin
        meas_q <= 1'b1;
        cnt_q  <= CW'(1);
      end else if (meas_q && !rx_level) begin
        if (cnt_q != CW'(SYNC_MIN)) cnt_q <= cnt_q + CW'(1);
      end else if (rise) begin
        meas_q <= 1'b0;
      end
    end
  end

  // R8: own drive hides the pin from qualification
  assert_masked_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mask |=> !sync_hit);
  // R7: saturating counter never exceeds the threshold
  assert_cnt_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_q && cnt_q == CW'(SYNC_MIN) && !rx_level && !mask) |=> cnt_q == CW'(SYNC_MIN));
endmodule

// File: rtl/dbg1w_seq.sv
module dbg1w_seq
  import dbg1w_pkg::*;
#(
  parameter int ACK_LEN  = 16,
  parameter int RESP_DLY = 16,
  parameter int RESP_LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_hit,
  input  logic cmd_busy,
  input  logic cmd_done,
  output logic pin_oe,
  output logic pin_out,
  output logic cmd_abort
);
  localparam int MAXL = (ACK_LEN > RESP_LEN) ?
                        ((ACK_LEN > RESP_DLY) ? ACK_LEN : RESP_DLY) :
                        ((RESP_LEN > RESP_DLY) ? RESP_LEN : RESP_DLY);
  localparam int TW = $clog2(MAXL + 1);

  seq_state_t    state_q;
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tmr_q     <= '0;
      cmd_abort <= 1'b0;
    end else begin
      cmd_abort <= sync_hit & (cmd_busy | cmd_done);
      unique case (state_q)
        ST_IDLE: begin
          tmr_q <= '0;
          if (sync_hit)      state_q <= ST_RSP_WAIT;
          else if (cmd_done) state_q <= ST_ACK_LO;
        end
        ST_ACK_LO: begin
          if (tmr_q == TW'(ACK_LEN - 1)) begin
            state_q <= ST_ACK_HI;
            tmr_q   <= '0;
          end else tmr_q <= tmr_q + TW'(1);
        end
        ST_ACK_HI: state_q <= ST_IDLE;
        ST_RSP_WAIT: begin
          if (sync_hit) tmr_q <= '0;
          else if (tmr_q == TW'(RESP_DLY - 1)) begin
            state_q <= ST_RSP_LO;
            tmr_q   <= '0;
          end else tmr_q <= tmr_q + TW'(1);
        end
        ST_RSP_LO: begin
          if (tmr_q == TW'(RESP_LEN - 1)) begin
            state_q <= ST_RSP_HI;
            tmr_q   <= '0;
          end else tmr_q <= tmr_q + TW'(1);
        end
        ST_RSP_HI: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign pin_oe  = (state_q == ST_ACK_LO) || (state_q == ST_ACK_HI) ||
                   (state_q == ST_RSP_LO) || (state_q == ST_RSP_HI);
  assign pin_out = (state_q == ST_ACK_HI) || (state_q == ST_RSP_HI);

  // R3: abort is a single-cycle strobe
  assert_abort_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> !cmd_abort);
  // R3: abort only follows a qualified request
  assert_abort_after_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |-> $past(sync_hit));
  // R4 / R6: every drive period opens low
  assert_drive_starts_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_oe) |-> !pin_out);
  // R6: speedup lasts one cycle, then release
  assert_speedup_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && pin_out) |=> !pin_oe);
  // R9: a request beats a same-cycle completion
  assert_sync_beats_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hit && cmd_done && state_q == ST_IDLE) |=> !pin_oe);
endmodule

// File: rtl/dbg1w_sync_ack.sv
module dbg1w_sync_ack #(
  parameter int SYNC_STAGES = 2,
  parameter int SYNC_MIN    = 128,
  parameter int ACK_LEN     = 16,
  parameter int RESP_DLY    = 16,
  parameter int RESP_LEN    = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic cmd_busy,
  input  logic cmd_done,
  output logic pin_oe,
  output logic pin_out,
  output logic rx_level,
  output logic cmd_abort
);
  logic sync_hit;

  dbg1w_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(rx_level)
  );

  dbg1w_low_meter #(.SYNC_MIN(SYNC_MIN)) u_meter (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .mask(pin_oe),
    .sync_hit(sync_hit)
  );

  dbg1w_seq #(.ACK_LEN(ACK_LEN), .RESP_DLY(RESP_DLY), .RESP_LEN(RESP_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .sync_hit(sync_hit), .cmd_busy(cmd_busy),
    .cmd_done(cmd_done), .pin_oe(pin_oe), .pin_out(pin_out), .cmd_abort(cmd_abort)
  );
endmodule

// File: tb/dbg1w_sync_ack_test.sv
module dbg1w_sync_ack_test;
  localparam int SYNC_MIN = 128, ACK_LEN = 16, RESP_DLY = 16, RESP_LEN = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_low = 1'b0, cmd_busy = 1'b0, cmd_done = 1'b0;
  logic pin_oe, pin_out, rx_level, cmd_abort;
  logic pin_in;
  int total = 0, bad = 0, cyc = 0;
  int ab_cnt, ab_edge, oe_first, lo_cnt, hi_cnt;

  assign pin_in = pin_oe ? pin_out : ~host_low;

  dbg1w_sync_ack uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cmd_busy(cmd_busy),
    .cmd_done(cmd_done), .pin_oe(pin_oe), .pin_out(pin_out),
    .rx_level(rx_level), .cmd_abort(cmd_abort)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_sync(input int len);
    return (len >= SYNC_MIN) ? 1 : 0;
  endfunction

  function automatic int exp_abort(input int len, input bit busy, input bit done);
    return (exp_sync(len) != 0 && (busy || done)) ? 1 : 0;
  endfunction

  task automatic host_pulse(input int n);
    host_low = 1'b1;
    repeat (n) @(negedge clk);
    host_low = 1'b0;
  endtask

  // edges counted from the negedge where this task starts
  task automatic observe(input int n, input int done_edge, input int hf, input int ht);
    ab_cnt = 0; ab_edge = 0; oe_first = 0; lo_cnt = 0; hi_cnt = 0;
    cmd_done = (done_edge == 1);
    if (ht != 0) host_low = (hf <= 1 && ht >= 1);
    for (int e = 1; e <= n; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (cmd_abort) begin ab_cnt++; if (ab_edge == 0) ab_edge = e; end
      if (pin_oe && oe_first == 0) oe_first = e;
      if (pin_oe && !pin_out) lo_cnt++;
      if (pin_oe && pin_out) hi_cnt++;
      cmd_done = (done_edge == e + 1);
      if (ht != 0) host_low = (e + 1 >= hf && e + 1 <= ht);
    end
  endtask

  task automatic run_sync(input int len, input bit busy, input string tag);
    cmd_busy = busy;
    host_pulse(len);
    observe(200, 0, 0, 0);
    cmd_busy = 1'b0;
    if (exp_sync(len) != 0) begin
      check({tag, " R4 response start"}, oe_first, RESP_DLY + 3);
      check({tag, " R4 response low"}, lo_cnt, RESP_LEN);
      check({tag, " R4 response speedup"}, hi_cnt, 1);
    end else begin
      check({tag, " R2 no drive on short pulse"}, oe_first, 0);
    end
    check({tag, " R3 abort count"}, ab_cnt, exp_abort(len, busy, 1'b0));
    if (exp_abort(len, busy, 1'b0) != 0) check({tag, " R3 abort edge"}, ab_edge, 3);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 pin_oe", int'(pin_oe), 0);
    check("R10 cmd_abort", int'(cmd_abort), 0);
    check("R10 rx_level", int'(rx_level), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 synchroniser latency
    host_low = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2 rx_level after one edge", int'(rx_level), 1);
    @(posedge clk); @(negedge clk);
    check("R2 rx_level after two edges", int'(rx_level), 0);
    host_low = 1'b0;
    repeat (10) @(negedge clk);

    // R6 acknowledge
    observe(40, 1, 0, 0);
    check("R6 ack start", oe_first, 1);
    check("R6 ack low", lo_cnt, ACK_LEN);
    check("R6 ack speedup", hi_cnt, 1);

    // R1 boundaries
    run_sync(127, 1'b1, "R1 len127");
    run_sync(128, 1'b1, "R1 len128");
    run_sync(128, 1'b0, "R3 idle no abort");

    // R7 saturation
    run_sync(600, 1'b1, "R7 len600");

    // R5 acknowledge right after response
    observe(40, 1, 0, 0);
    check("R5 ack start after response", oe_first, 1);
    check("R5 ack low after response", lo_cnt, ACK_LEN);

    // R9 done in qualifying cycle (rise seen between edges 2 and 3)
    host_pulse(150);
    observe(200, 3, 0, 0);
    check("R9 abort count", ab_cnt, 1);
    check("R9 abort edge", ab_edge, 3);
    check("R9 response start", oe_first, RESP_DLY + 3);
    check("R9 no ack, low len", lo_cnt, RESP_LEN);

    // R8 host pulse overlapping acknowledge
    observe(220, 1, 3, 30);
    check("R8 ack start", oe_first, 1);
    check("R8 ack low unchanged", lo_cnt, ACK_LEN);
    check("R8 ack speedup unchanged", hi_cnt, 1);
    check("R8 no abort", ab_cnt, 0);

    // random mix
    for (int i = 0; i < 20; i++) begin
      int len;
      bit busy;
      len  = ($urandom % 2 == 0) ? 1 + int'($urandom % 127) : 100 + int'($urandom % 200);
      busy = 1'($urandom % 2);
      run_sync(len, busy, "R1 random");
      repeat (1 + int'($urandom % 5)) @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule